// File: doc/BRIEF.md
# Pipeline Hazard and Flush Control

This block is the control core of a five-stage in-order pipeline: fetch, decode with register read, execute, memory and writeback. Every register carries a stale bit that is set while a write to it is still travelling down the pipe. An instruction in decode that reads a stale register takes the execute-stage result over a bypass when the producer sitting in execute is an add. Otherwise it holds the front end until the producer has written the register file. Branches are resolved in execute under a static not-taken guess. A taken branch turns the two younger instructions into bubbles and points fetch at the target.

To exercise this control, the block carries a deliberately small datapath: a register file, an adder, an unsigned less-than compare, and a load whose value only appears in the memory stage. Instructions come in from outside, one per cycle, at the fetch address the block drives. Results leave through a writeback port in program order.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the fetch address is 0 and no writeback, stall or flush is signalled.
- R2: An instruction word is {op[1:0], rd, rs1, rs2, imm[PC_W-1:0]}, with op in the top bits and imm in the low bits. The op codes are: 0 no-op; 1 add (rd = rs1 + rs2); 2 load (rd = imm zero-extended, value produced in the memory stage); 3 branch (go to imm when rs1 < rs2, unsigned). Adds and loads retire on the writeback port in program order, four cycles after their fetch when nothing stalls.
- R3: A register becomes stale when a writer of it moves from decode into execute. It is cleared at writeback only if no younger writer of the same register is in execute or memory.
- R4: A stale source whose producer is an add now in execute is taken from the execute result, with no stall. This applies to branches as well.
- R5: Any other stale source stalls decode until the value is in the register file. During a stall the fetch address and the decode instruction hold, and a bubble enters execute.
- R6: A taken branch raises flush for one cycle. The two younger instructions never retire, and the fetch address equals the branch target in the next cycle.
- R7: A branch that is not taken causes no flush, and fetch keeps counting up by one.
- R8: Register 0 is never stale and always reads 0. A write to it is retired on the port but has no effect.
- R9: When a flush and a stall fall in the same cycle, the flush wins and the stall output stays low.
- R10: A squashed instruction leaves no stale mark: a later reader of its destination neither stalls nor sees its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 2+3*log2(NREG)+PC_W | Instruction word at the current fetch address |
| fetch_pc_o | output | PC_W | Fetch address |
| wb_valid_o | output | 1 | An add or load retires this cycle |
| wb_rd_o | output | log2(NREG) | Destination of the retiring instruction |
| wb_data_o | output | XLEN | Value written by the retiring instruction |
| stall_o | output | 1 | Front end held this cycle |
| flush_o | output | 1 | Taken branch squashes younger instructions this cycle |

## Verification
The bench builds the block with XLEN=16, NREG=8 and PC_W=7. With these values a program of 32 words fits in a small bench-side store, and seven-bit immediates hold both distinct load values and branch targets. Every hazard distance then fits into a few cycles and can be checked cycle by cycle: a producer in execute, a load in execute, a producer in memory or writeback, two writers of the same register, and a branch whose operand comes over the bypass. The branch target lies far enough ahead that a squashed instruction would show on the writeback port if it retired.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_ADD  = 2'd1,
        OP_LOAD = 2'd2,
        OP_BLT  = 2'd3
    } op_e;
endpackage

// File: rtl/hz_regfile.sv
module hz_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   ra_a,
    input  logic [RW-1:0]   ra_b,
    output logic [XLEN-1:0] rdat_a,
    output logic [XLEN-1:0] rdat_b,
    input  logic            we,
    input  logic [RW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic            set_en,
    input  logic [RW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_idx,
    output logic [NREG-1:0] stale_o
);
    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];
    logic [NREG-1:0] stale_d, stale_q;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i]  = regs_q[i];
            stale_d[i] = stale_q[i];
            if (we && waddr == RW'(i))
                regs_d[i] = wdata;
            if (clr_en && clr_idx == RW'(i))
                stale_d[i] = 1'b0;
            if (set_en && set_idx == RW'(i))
                stale_d[i] = 1'b1;
        end
        regs_d[0]  = '0;
        stale_d[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= '0;
            stale_q <= '0;
        end else begin
            regs_q  <= regs_d;
            stale_q <= stale_d;
        end
    end

    assign rdat_a  = regs_q[ra_a];
    assign rdat_b  = regs_q[ra_b];
    assign stale_o = stale_q;

    // R3: an issued writer marks its destination
    p_set_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> stale_q[$past(set_idx)]);

    // R3: a permitted clear removes the mark unless re-set in the same cycle
    p_clear_unmarks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !stale_q[$past(clr_idx)]);
endmodule

// File: rtl/hz_hazard.sv
module hz_hazard #(
    parameter int NREG = 16,
    localparam int RW = $clog2(NREG)
) (
    input  logic [1:0]         use_i,
    input  logic [1:0][RW-1:0] rs_i,
    input  logic [NREG-1:0]    stale_i,
    input  logic               ex_wr_i,
    input  logic               ex_alu_i,
    input  logic [RW-1:0]      ex_rd_i,
    output logic [1:0]         fwd_o,
    output logic               stall_o
);
    logic [1:0] blk;

    for (genvar k = 0; k < 2; k++) begin : g_src
        logic need, hit;
        assign need     = use_i[k] && (rs_i[k] != '0) && stale_i[rs_i[k]];
        assign hit      = ex_wr_i && ex_alu_i && (ex_rd_i == rs_i[k]);
        assign fwd_o[k] = need && hit;
        assign blk[k]   = need && !hit;
    end

    assign stall_o = |blk;
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl #(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    parameter int PC_W = 10,
    localparam int RW = $clog2(NREG),
    localparam int INSTR_W = 2 + 3 * RW + PC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [PC_W-1:0]    fetch_pc_o,
    output logic               wb_valid_o,
    output logic [RW-1:0]      wb_rd_o,
    output logic [XLEN-1:0]    wb_data_o,
    output logic               stall_o,
    output logic               flush_o
);
    import hz_pkg::*;

    typedef struct packed {
        logic            v;
        op_e             op;
        logic [RW-1:0]   rd;
        logic [RW-1:0]   rs1;
        logic [RW-1:0]   rs2;
        logic [PC_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic            v;
        op_e             op;
        logic [RW-1:0]   rd;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [PC_W-1:0] imm;
    } exe_t;

    typedef struct packed {
        logic            v;
        op_e             op;
        logic [RW-1:0]   rd;
        logic [XLEN-1:0] res;
        logic [PC_W-1:0] imm;
    } mem_t;

    typedef struct packed {
        logic            v;
        logic [RW-1:0]   rd;
        logic [XLEN-1:0] data;
    } wbk_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        dec_t            ifid;
        exe_t            idex;
        mem_t            exmem;
        wbk_t            memwb;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] rf_a, rf_b, opa, opb, ex_sum;
    logic [NREG-1:0] stale;
    logic [1:0]      fwd;
    logic            hz_stall, ex_taken, ex_wr, mem_wr, id_wr;
    logic            use_a, use_b, set_en, clr_en;

    // decode-stage operand use and write intent
    assign use_a = st_q.ifid.v && (st_q.ifid.op == OP_ADD || st_q.ifid.op == OP_BLT);
    assign use_b = use_a;
    assign id_wr = st_q.ifid.v && (st_q.ifid.op == OP_ADD || st_q.ifid.op == OP_LOAD)
                   && st_q.ifid.rd != '0;

    // execute-stage result and branch outcome
    assign ex_sum   = st_q.idex.a + st_q.idex.b;
    assign ex_taken = st_q.idex.v && st_q.idex.op == OP_BLT && st_q.idex.a < st_q.idex.b;
    assign ex_wr    = st_q.idex.v && (st_q.idex.op == OP_ADD || st_q.idex.op == OP_LOAD)
                      && st_q.idex.rd != '0;
    assign mem_wr   = st_q.exmem.v && (st_q.exmem.op == OP_ADD || st_q.exmem.op == OP_LOAD)
                      && st_q.exmem.rd != '0;

    hz_hazard #(.NREG(NREG)) u_hazard (
        .use_i   ({use_b, use_a}),
        .rs_i    ({st_q.ifid.rs2, st_q.ifid.rs1}),
        .stale_i (stale),
        .ex_wr_i (ex_wr),
        .ex_alu_i(st_q.idex.op == OP_ADD),
        .ex_rd_i (st_q.idex.rd),
        .fwd_o   (fwd),
        .stall_o (hz_stall)
    );

    assign flush_o = ex_taken;
    assign stall_o = hz_stall && !ex_taken;

    assign set_en = id_wr && !stall_o && !flush_o;
    assign clr_en = st_q.memwb.v && st_q.memwb.rd != '0
                    && !(ex_wr && st_q.idex.rd == st_q.memwb.rd)
                    && !(mem_wr && st_q.exmem.rd == st_q.memwb.rd);

    hz_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (st_q.ifid.rs1),
        .ra_b   (st_q.ifid.rs2),
        .rdat_a (rf_a),
        .rdat_b (rf_b),
        .we     (st_q.memwb.v),
        .waddr  (st_q.memwb.rd),
        .wdata  (st_q.memwb.data),
        .set_en (set_en),
        .set_idx(st_q.ifid.rd),
        .clr_en (clr_en),
        .clr_idx(st_q.memwb.rd),
        .stale_o(stale)
    );

    assign opa = fwd[0] ? ex_sum : rf_a;
    assign opb = fwd[1] ? ex_sum : rf_b;

    always_comb begin
        st_d = st_q;

        // fetch
        if (flush_o) begin
            st_d.pc     = st_q.idex.imm;
            st_d.ifid.v = 1'b0;
        end else if (!stall_o) begin
            st_d.pc        = st_q.pc + 1'b1;
            st_d.ifid.v    = 1'b1;
            st_d.ifid.op   = op_e'(instr_i[INSTR_W-1 -: 2]);
            st_d.ifid.rd   = instr_i[INSTR_W-3 -: RW];
            st_d.ifid.rs1  = instr_i[INSTR_W-3-RW -: RW];
            st_d.ifid.rs2  = instr_i[INSTR_W-3-2*RW -: RW];
            st_d.ifid.imm  = instr_i[PC_W-1:0];
        end

        // decode -> execute
        if (flush_o || stall_o) begin
            st_d.idex.v = 1'b0;
        end else begin
            st_d.idex.v   = st_q.ifid.v;
            st_d.idex.op  = st_q.ifid.op;
            st_d.idex.rd  = st_q.ifid.rd;
            st_d.idex.a   = opa;
            st_d.idex.b   = opb;
            st_d.idex.imm = st_q.ifid.imm;
        end

        // execute -> memory
        st_d.exmem.v   = st_q.idex.v;
        st_d.exmem.op  = st_q.idex.op;
        st_d.exmem.rd  = st_q.idex.rd;
        st_d.exmem.res = ex_sum;
        st_d.exmem.imm = st_q.idex.imm;

        // memory -> writeback
        st_d.memwb.v    = st_q.exmem.v
                          && (st_q.exmem.op == OP_ADD || st_q.exmem.op == OP_LOAD);
        st_d.memwb.rd   = st_q.exmem.rd;
        st_d.memwb.data = (st_q.exmem.op == OP_LOAD) ? XLEN'(st_q.exmem.imm)
                                                     : st_q.exmem.res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fetch_pc_o = st_q.pc;
    assign wb_valid_o = st_q.memwb.v;
    assign wb_rd_o    = st_q.memwb.rd;
    assign wb_data_o  = st_q.memwb.data;

    // R5: a stall keeps the fetch address
    p_stall_holds_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> $stable(fetch_pc_o));

    // R5: a stall sends a bubble into execute
    p_stall_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !st_q.idex.v);

    // R6: a taken branch redirects fetch and empties the two younger slots
    p_flush_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (fetch_pc_o == $past(st_q.idex.imm)) && !st_q.ifid.v && !st_q.idex.v);

    // R7: without stall or flush, fetch advances by one
    p_seq_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o && !stall_o) |=> fetch_pc_o == PC_W'($past(fetch_pc_o) + 1'b1));

    // R4: an issuing reader of a stale nonzero source must use the bypass
    p_stale_needs_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (use_a && st_q.ifid.rs1 != '0 && stale[st_q.ifid.rs1] && !stall_o && !flush_o)
        |-> fwd[0]);
endmodule

// File: tb/test_hz_pipe_ctrl.sv
`timescale 1ns/1ps
module test_hz_pipe_ctrl;
    localparam int TB_XLEN = 16;
    localparam int TB_NREG = 8;
    localparam int TB_PCW  = 7;
    localparam int TB_IW   = 2 + 3 * 3 + TB_PCW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TB_IW-1:0]  instr;
    logic [TB_PCW-1:0] fetch_pc;
    logic              wb_valid, stall, flush;
    logic [2:0]        wb_rd;
    logic [TB_XLEN-1:0] wb_data;

    logic [TB_IW-1:0] imem [32];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wb_n, st_cnt, fl_cnt;
    int wb_rd_l [64];
    int wb_dat  [64];
    int wb_cy   [64];
    int pc_log  [64];
    int fl_log  [64];

    always #10 clk = ~clk;

    assign instr = imem[fetch_pc[4:0]];

    hz_pipe_ctrl #(.XLEN(TB_XLEN), .NREG(TB_NREG), .PC_W(TB_PCW)) i_hz_pipe_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .fetch_pc_o(fetch_pc),
        .wb_valid_o(wb_valid),
        .wb_rd_o   (wb_rd),
        .wb_data_o (wb_data),
        .stall_o   (stall),
        .flush_o   (flush)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && cyc < 64) begin
            pc_log[cyc] = int'(fetch_pc);
            fl_log[cyc] = int'(flush);
            st_cnt += int'(stall);
            fl_cnt += int'(flush);
            if (wb_valid && wb_n < 64) begin
                wb_rd_l[wb_n] = int'(wb_rd);
                wb_dat[wb_n]  = int'(wb_data);
                wb_cy[wb_n]   = cyc;
                wb_n++;
            end
        end
    end

    localparam logic [1:0] NOP = 2'd0, ADD = 2'd1, LD = 2'd2, BLT = 2'd3;

    function automatic logic [TB_IW-1:0] enc(logic [1:0] op, int rd, int rs1, int rs2, int imm);
        return {op, 3'(rd), 3'(rs1), 3'(rs2), 7'(imm)};
    endfunction

    function automatic int wb_idx(int rd);
        for (int i = 0; i < wb_n; i++)
            if (wb_rd_l[i] == rd) return i;
        return -1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_wb(string tag, int rd, int exp_data, int exp_cyc);
        int i;
        i = wb_idx(rd);
        chk({tag, " data"}, (i >= 0) ? wb_dat[i] : -1, exp_data);
        chk({tag, " cycle"}, (i >= 0) ? wb_cy[i] : -1, exp_cyc);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) imem[i] = '0;
    endtask

    task automatic run_prog(int n);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        wb_n = 0; st_cnt = 0; fl_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            pc_log[i] = -1;
            fl_log[i] = -1;
        end
        #5 rst_n = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        clear_mem();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 fetch pc in reset", int'(fetch_pc), 0);
        chk("R1 wb_valid in reset", int'(wb_valid), 0);
        chk("R1 stall in reset", int'(stall), 0);
        chk("R1 flush in reset", int'(flush), 0);
        run_prog(2);
        chk("R1 pc first cycle", pc_log[0], 0);
    endtask

    // R2, R4: encoding, retire timing, execute bypass
    task automatic t_forward();
        clear_mem();
        imem[0] = enc(LD, 1, 0, 0, 5);
        imem[4] = enc(ADD, 2, 1, 1, 0);
        imem[5] = enc(ADD, 3, 2, 2, 0);
        imem[6] = enc(ADD, 5, 3, 1, 0);
        run_prog(16);
        chk_wb("R2 load r1", 1, 5, 4);
        chk_wb("R2 add r2", 2, 10, 8);
        chk_wb("R4 fwd r3", 3, 20, 9);
        chk_wb("R4 fwd r5", 5, 25, 10);
        chk("R4 no stall", st_cnt, 0);
        chk("R2 writebacks", wb_n, 4);
    endtask

    // R5: load in execute stalls until written back
    task automatic t_load_use();
        clear_mem();
        imem[0] = enc(LD, 1, 0, 0, 7);
        imem[1] = enc(ADD, 2, 1, 0, 0);
        imem[2] = enc(LD, 3, 0, 0, 9);
        run_prog(14);
        chk("R5 load-use stalls", st_cnt, 3);
        chk("R5 pc held", pc_log[4], 2);
        chk_wb("R5 dependent r2", 2, 7, 8);
        chk_wb("R5 younger r3", 3, 9, 9);
    endtask

    // R5: producer in memory stage cannot be bypassed
    task automatic t_mem_producer();
        clear_mem();
        imem[0] = enc(LD, 1, 0, 0, 3);
        imem[4] = enc(ADD, 2, 1, 1, 0);
        imem[5] = enc(ADD, 3, 1, 0, 0);
        imem[6] = enc(ADD, 4, 2, 2, 0);
        run_prog(16);
        chk("R5 mem producer stalls", st_cnt, 2);
        chk_wb("R5 independent r3", 3, 3, 9);
        chk_wb("R5 late r4", 4, 12, 12);
    endtask

    // R6, R9, R10: taken branch, flush over stall, squashed leaves no mark
    task automatic t_taken();
        clear_mem();
        imem[0]  = enc(LD, 1, 0, 0, 1);
        imem[1]  = enc(LD, 2, 0, 0, 2);
        imem[5]  = enc(LD, 4, 0, 0, 9);
        imem[6]  = enc(BLT, 0, 1, 2, 12);
        imem[7]  = enc(ADD, 5, 4, 0, 0);
        for (int i = 8; i < 12; i++) imem[i] = enc(LD, 7, 0, 0, 119);
        imem[12] = enc(LD, 6, 0, 0, 102);
        imem[13] = enc(ADD, 3, 5, 0, 0);
        run_prog(20);
        chk("R6 flush cycle", fl_log[8], 1);
        chk("R6 flush count", fl_cnt, 1);
        chk("R6 redirect pc", pc_log[9], 12);
        chk("R6 squashed r5 absent", wb_idx(5), -1);
        chk("R6 squashed r7 absent", wb_idx(7), -1);
        chk_wb("R6 older r4", 4, 9, 9);
        chk_wb("R6 target r6", 6, 102, 13);
        chk("R9 flush beats stall", st_cnt, 0);
        chk_wb("R10 reader of squashed dest", 3, 0, 14);
        chk("R10 writebacks", wb_n, 5);
    endtask

    // R7, R4: not-taken branch with bypassed operand
    task automatic t_not_taken();
        clear_mem();
        imem[0] = enc(LD, 1, 0, 0, 4);
        imem[4] = enc(ADD, 2, 1, 0, 0);
        imem[5] = enc(BLT, 0, 2, 1, 20);
        imem[6] = enc(LD, 3, 0, 0, 17);
        run_prog(14);
        chk("R7 no flush", fl_cnt, 0);
        chk("R7 sequential pc", pc_log[8], 8);
        chk("R4 branch bypass no stall", st_cnt, 0);
        chk_wb("R7 next r3", 3, 17, 10);
        chk_wb("R2 add r2", 2, 4, 8);
    endtask

    // R8: register zero
    task automatic t_zero_reg();
        clear_mem();
        imem[0] = enc(LD, 0, 0, 0, 99);
        imem[1] = enc(ADD, 1, 0, 0, 0);
        imem[6] = enc(ADD, 3, 0, 0, 0);
        run_prog(14);
        chk("R8 never stale", st_cnt, 0);
        chk_wb("R8 read right after", 1, 0, 5);
        chk_wb("R8 read after write", 3, 0, 10);
    endtask

    // R3: two writers of one register
    task automatic t_waw();
        clear_mem();
        imem[0] = enc(LD, 1, 0, 0, 1);
        imem[1] = enc(LD, 1, 0, 0, 2);
        imem[4] = enc(ADD, 2, 1, 0, 0);
        run_prog(14);
        chk("R3 stall for younger writer", st_cnt, 1);
        chk_wb("R3 reads younger value", 2, 2, 9);
    endtask

    initial begin
        #4_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wb_n = 0; st_cnt = 0; fl_cnt = 0;
        t_reset();
        t_forward();
        t_load_use();
        t_mem_producer();
        t_taken();
        t_not_taken();
        t_zero_reg();
        t_waw();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule